// File: doc/BRIEF.md
# I2C Misplaced Start/Stop Detector

This block sits beside the byte engine of an I2C slave and watches the bus lines for a Start or a Stop condition that arrives while a byte is still being shifted. Such a condition is a protocol violation. The block turns it into a sticky bus-error flag and an error interrupt that can be masked. It also produces single-cycle pulses that tell the byte engine to throw away the partial byte and let go of SCL and SDA.

The block tells the two kinds of violation apart. A Start that arrives too early is treated as a repeated Start, so the slave is sent back to waiting for an address byte. A Stop that arrives too early is handled like any ordinary Stop, so the slave returns to idle. The raw line levels pass through a configurable synchroniser before they are judged. The slave state and the bit counter come from the neighbouring engine and are sampled in the cycle the condition is detected. Software clears the error flag with a write-one-to-clear strobe.

Top module: `bus_cond_guard`

## Requirements
- R1: While reset is high, and at the first sample after it, bus_err, err_irq, release_lines, drop_byte and cmd_valid are all 0.
- R2: A Start condition (SDA falling while SCL stays high) seen inside the byte window sets bus_err.
- R3: A Stop condition (SDA rising while SCL stays high) seen inside the byte window sets bus_err.
- R4: The byte window is slv_state non-zero (1 = address, 2 = receive, 3 = transmit) together with bit_cnt from 1 to 8. A Start or Stop outside this window does not alter any output. This covers slv_state 0 (idle), bit_cnt 0, and bit_cnt 9 to 15. An SDA change while SCL is low does not alter any output either.
- R5: err_irq is high in a cycle exactly when bus_err is high and err_irq_en was high at the preceding rising edge.
- R6: bus_err stays set until err_clr is sampled high at a rising edge, after which it reads 0. If a new error is detected at the same edge as err_clr, bus_err stays 1.
- R7: For each detected error, release_lines and drop_byte pulse high for exactly one cycle, at the same edge that sets bus_err.
- R8: A misplaced Start pulses cmd_valid for one cycle with cmd_state = 1 (wait for address).
- R9: A misplaced Stop pulses cmd_valid for one cycle with cmd_state = 0 (idle).
- R10: With the default of two synchroniser stages, all outputs respond at the third rising clock edge after the line change is applied. Nothing changes at the first or second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| slv_state | input | 2 | Slave engine state: 0 idle, 1 address, 2 receive, 3 transmit |
| bit_cnt | input | CNT_W | Bit index within the current byte, 1 to 8 data, 9 acknowledge, 0 none |
| err_irq_en | input | 1 | Error interrupt enable |
| err_clr | input | 1 | Write-one-to-clear strobe for bus_err |
| bus_err | output | 1 | Sticky bus-error flag |
| err_irq | output | 1 | Masked error interrupt |
| release_lines | output | 1 | One-cycle request to release SCL and SDA |
| drop_byte | output | 1 | One-cycle request to discard the partial byte |
| cmd_valid | output | 1 | Recovery command strobe for the slave engine |
| cmd_state | output | 2 | Recovery target state: 1 address wait, 0 idle |

## Verification
The error-setting path and the software clear can fall in the same cycle. This happens when err_clr reaches the flag at the same edge as a freshly detected misplaced condition. The bench provokes it by raising err_clr one cycle after the SDA edge has passed the second synchroniser stage, so the strobe and the detection meet at the third edge. The bench then expects bus_err to read 1. A plain clear issued afterwards must bring bus_err back to 0.

// File: rtl/bcg_pkg.sv
`timescale 1ns/1ps
package bcg_pkg;

    // Slave engine states as seen by the detector.
    typedef enum logic [1:0] {
        SL_IDLE = 2'd0,
        SL_ADDR = 2'd1,
        SL_RXD  = 2'd2,
        SL_TXD  = 2'd3
    } slv_state_e;

    // Bus conditions recognised on the synchronised lines.
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_START = 2'd1,
        EV_STOP  = 2'd2
    } bus_ev_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_pair_t;

    typedef struct packed {
        logic       valid;
        slv_state_e state;
    } recov_cmd_t;

    localparam line_pair_t LINES_IDLE = '{scl: 1'b1, sda: 1'b1};

    // A misplaced Start behaves as a repeated Start, so the engine goes back to waiting
    // for an address. A misplaced Stop behaves as a plain Stop, so the engine goes idle.
    function automatic slv_state_e recovery_of(bus_ev_e ev);
        return (ev == EV_START) ? SL_ADDR : SL_IDLE;
    endfunction

endpackage

// File: rtl/bcg_sync.sv
`timescale 1ns/1ps
module bcg_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned LANES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] d,
    output logic [LANES-1:0] q
);
    // The stages reset to 1 because an idle I2C bus is high, so no edge is
    // reported right after reset.
    logic [LANES-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '1;
                else     stage[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '1;
                else     stage[s] <= stage[s-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/bcg_cond_detect.sv
`timescale 1ns/1ps
module bcg_cond_detect
    import bcg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_pair_t now,
    output bus_ev_e    ev
);
    line_pair_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= LINES_IDLE;
        else     prev <= now;
    end

    // SCL must be high on both samples, so SDA moved while SCL was steady high.
    always_comb begin
        ev = EV_NONE;
        if (now.scl && prev.scl) begin
            if (prev.sda && !now.sda)      ev = EV_START;
            else if (!prev.sda && now.sda) ev = EV_STOP;
        end
    end
endmodule

// File: rtl/bcg_err_ctrl.sv
`timescale 1ns/1ps
module bcg_err_ctrl
    import bcg_pkg::*;
#(
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned BYTE_BITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_e          ev,
    input  slv_state_e       state,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic             irq_en,
    input  logic             clr,
    output logic             err,
    output logic             irq,
    output logic             release_req,
    output logic             drop_req,
    output recov_cmd_t       cmd
);
    localparam logic [CNT_W-1:0] FIRST_BIT = CNT_W'(1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_BITS);

    logic in_window;
    logic hit;
    logic err_next;

    // The window covers the data bits only. The acknowledge slot and idle time are outside it.
    assign in_window = (state != SL_IDLE) && (bit_cnt >= FIRST_BIT) && (bit_cnt <= LAST_BIT);
    assign hit       = (ev != EV_NONE) && in_window;
    // A new error wins over a clear strobe at the same edge.
    assign err_next  = hit || (err && !clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            err         <= 1'b0;
            irq         <= 1'b0;
            release_req <= 1'b0;
            drop_req    <= 1'b0;
            cmd         <= '{valid: 1'b0, state: SL_IDLE};
        end else begin
            err         <= err_next;
            irq         <= err_next && irq_en;
            release_req <= hit;
            drop_req    <= hit;
            cmd.valid   <= hit;
            if (hit) cmd.state <= recovery_of(ev);
        end
    end
endmodule

// File: rtl/bus_cond_guard.sv
`timescale 1ns/1ps
module bus_cond_guard
    import bcg_pkg::*;
#(
    parameter int unsigned CNT_W       = 4,
    parameter int unsigned BYTE_BITS   = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [1:0]       slv_state,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic             err_irq_en,
    input  logic             err_clr,
    output logic             bus_err,
    output logic             err_irq,
    output logic             release_lines,
    output logic             drop_byte,
    output logic             cmd_valid,
    output logic [1:0]       cmd_state
);
    localparam int unsigned LANES = 2;

    logic [LANES-1:0] raw_lines;
    logic [LANES-1:0] sync_lines;
    line_pair_t       lines;
    bus_ev_e          ev;
    recov_cmd_t       cmd;

    assign raw_lines = {scl_i, sda_i};

    bcg_sync #(.STAGES(SYNC_STAGES), .LANES(LANES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lines),
        .q   (sync_lines)
    );

    assign lines = '{scl: sync_lines[1], sda: sync_lines[0]};

    bcg_cond_detect u_detect (
        .clk (clk),
        .rst (rst),
        .now (lines),
        .ev  (ev)
    );

    bcg_err_ctrl #(.CNT_W(CNT_W), .BYTE_BITS(BYTE_BITS)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .state       (slv_state_e'(slv_state)),
        .bit_cnt     (bit_cnt),
        .irq_en      (err_irq_en),
        .clr         (err_clr),
        .err         (bus_err),
        .irq         (err_irq),
        .release_req (release_lines),
        .drop_req    (drop_byte),
        .cmd         (cmd)
    );

    assign cmd_valid = cmd.valid;
    assign cmd_state = cmd.state;
endmodule

// File: rtl/bcg_checker.sv
`timescale 1ns/1ps
module bcg_checker #(
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned BYTE_BITS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       slv_state,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             err_irq_en,
    input logic             err_clr,
    input logic             bus_err,
    input logic             err_irq,
    input logic             release_lines,
    input logic             drop_byte,
    input logic             cmd_valid,
    input logic [1:0]       cmd_state
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!bus_err && !err_irq && !release_lines && !drop_byte && !cmd_valid));

    assert_window_R4: assert property (@(posedge clk) disable iff (rst)
        release_lines |-> ($past(slv_state) != 2'd0 && $past(bit_cnt) >= CNT_W'(1)
                           && $past(bit_cnt) <= CNT_W'(BYTE_BITS)));

    assert_irq_mask_R5: assert property (@(posedge clk) disable iff (rst)
        !err_irq_en |=> !err_irq);

    assert_irq_follow_R5: assert property (@(posedge clk) disable iff (rst)
        err_irq_en |=> (err_irq == bus_err));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_err && !err_clr) |=> bus_err);

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        err_clr |=> (!bus_err || release_lines));

    assert_release_err_R7: assert property (@(posedge clk) disable iff (rst)
        release_lines |-> (bus_err && drop_byte));

    assert_cmd_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (release_lines && drop_byte));

    assert_cmd_code_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_state == 2'd0 || cmd_state == 2'd1));
endmodule

bind bus_cond_guard bcg_checker #(.CNT_W(CNT_W), .BYTE_BITS(BYTE_BITS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .slv_state     (slv_state),
    .bit_cnt       (bit_cnt),
    .err_irq_en    (err_irq_en),
    .err_clr       (err_clr),
    .bus_err       (bus_err),
    .err_irq       (err_irq),
    .release_lines (release_lines),
    .drop_byte     (drop_byte),
    .cmd_valid     (cmd_valid),
    .cmd_state     (cmd_state)
);

// File: tb/test_bus_cond_guard.sv
`timescale 1ns/1ps
module test_bus_cond_guard;
    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic [1:0] st = 2'd0;
    logic [CNT_W-1:0] cnt = '0;
    logic en = 1'b0;
    logic clr = 1'b0;
    logic bus_err, err_irq, release_lines, drop_byte, cmd_valid;
    logic [1:0] cmd_state;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus_cond_guard #(.CNT_W(CNT_W)) i_bus_cond_guard (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
        .slv_state(st), .bit_cnt(cnt), .err_irq_en(en), .err_clr(clr),
        .bus_err(bus_err), .err_irq(err_irq), .release_lines(release_lines),
        .drop_byte(drop_byte), .cmd_valid(cmd_valid), .cmd_state(cmd_state)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] outs();
        return {3'b0, bus_err, err_irq, release_lines, drop_byte, cmd_valid};
    endfunction

    // kind: 0 Start, 1 Stop, 2 SDA toggle with SCL low
    task automatic run_vec(input int s, input int c, input int kind, input bit e, input bit collide);
        bit exp_err;
        exp_err = (kind != 2) && (s != 0) && (c >= 1) && (c <= 8);
        @(negedge clk); st = 2'(s); cnt = CNT_W'(c); en = e; clr = 1'b1;
        @(negedge clk); clr = 1'b0; scl = 1'b0;
        @(negedge clk); sda = (kind == 1) ? 1'b0 : 1'b1;
        @(negedge clk); scl = (kind == 2) ? 1'b0 : 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 cleared before event", {7'b0, bus_err}, 8'h0);
        sda = ~sda;
        @(negedge clk);
        chk("R10 no response at edge 1", outs(), 8'h0);
        @(negedge clk);
        chk("R10 no response at edge 2", outs(), 8'h0);
        if (collide) clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        if (kind == 0)
            chk(exp_err ? "R2 start in window" : "R4 start outside window",
                outs(), exp_err ? {3'b0, 1'b1, e, 3'b111} : 8'h0);
        else if (kind == 1)
            chk(exp_err ? "R3 stop in window" : "R4 stop outside window",
                outs(), exp_err ? {3'b0, 1'b1, e, 3'b111} : 8'h0);
        else
            chk("R4 SDA change with SCL low", outs(), 8'h0);
        if (exp_err) begin
            if (kind == 0) chk("R8 start recovery code", {6'b0, cmd_state}, 8'h1);
            else           chk("R9 stop recovery code", {6'b0, cmd_state}, 8'h0);
        end
        @(negedge clk);
        chk("R7 single-cycle pulses", {5'b0, release_lines, drop_byte, cmd_valid}, 8'h0);
        chk("R6 sticky flag", {7'b0, bus_err}, {7'b0, exp_err});
        chk("R5 irq follows flag and enable", {7'b0, err_irq}, {7'b0, exp_err & e});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 outputs during reset", outs(), 8'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 outputs after reset", outs(), 8'h0);

        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 16; c++)
                for (int k = 0; k < 3; k++)
                    for (int e = 0; e < 2; e++)
                        run_vec(s, c, k, e[0], 1'b0);

        // Clear strobe and a new error meet at the same edge: set wins.
        run_vec(2, 4, 0, 1'b1, 1'b1);
        run_vec(3, 8, 1, 1'b0, 1'b1);
        // Flag is still set here; a lone clear now empties it.
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk("R6 plain clear", {7'b0, bus_err}, 8'h0);

        // Enable toggled while the flag is held.
        run_vec(1, 1, 0, 1'b0, 1'b0);
        chk("R5 masked while disabled", {7'b0, err_irq}, 8'h0);
        en = 1'b1;
        @(negedge clk);
        chk("R5 irq after enable", {7'b0, err_irq}, 8'h1);
        en = 1'b0;
        @(negedge clk);
        chk("R5 irq after disable", {7'b0, err_irq}, 8'h0);
        chk("R6 flag unaffected by enable", {7'b0, bus_err}, 8'h1);

        // Reset in the middle of operation.
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-run reset", outs(), 8'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule